// File: doc/BRIEF.md
# Memory Access Protection Checker

This block sits next to address translation and judges every memory request before it is allowed to reach memory. The request carries a linear address, an access size, a read/write flag and a code-fetch flag. The block also receives the current privilege level, two alignment-enable bits and the permission attributes of the translated page: present, user-accessible and writable. It returns a single registered result one clock after the request. The result is either a forwarded memory request or a fault report. It is never both.

Two families of checks run side by side on the same cycle. The first is an alignment check, which applies only to the least privileged level and only when both enable bits are set. The second is a pair of page checks: one tests whether the page may be reached from the current privilege domain, and the other tests whether the page allows the access type. Passing and failing requests take the same single registered cycle. A violation therefore adds no latency to good traffic, and it never produces a memory request. The page walk, translation storage and exception delivery are handled elsewhere.

Top module: `accchk_top`

## Requirements
- R1: A request with `reqValid` high that passes every check appears on the outputs on the next clock. `memValid` is 1 and carries the same address, size code, write and fetch flags. `faultValid` is 0 and `faultKind` is NONE (0).
- R2: At privilege 3, with both `ctlAlignMask` and `flgAlignChk` set, a misaligned access that has no page violation gives `faultValid`=1 and `faultKind`=ALIGN (1), with `faultCause`=0 and `faultAddr` equal to the request address.
- R3: At privilege 0, 1 or 2, no alignment fault is raised, whatever the enable bits are.
- R4: At privilege 3, no alignment fault is raised if either enable bit is clear.
- R5: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An access is misaligned when its address is not a multiple of its byte size.
- R6: An access at privilege 3 to a page whose user bit is clear raises a page fault (`faultKind`=PAGE, 2).
- R7: A write to a page whose writable bit is clear raises a page fault at every privilege level. A code fetch counts as a read even when `reqWrite` is high.
- R8: An access to a page whose present bit is clear raises a page fault.
- R9: When an access has both an alignment violation and a page violation, the page fault is reported. `faultCause` is {user, write, present} in bits 2..0. Here user means privilege 3, write means a write that is not a fetch, and present is the page's present bit. For anything other than a page fault, `faultCause` is 0.
- R10: A request with any violation never asserts `memValid`. `memValid` and `faultValid` are never high together.
- R11: A cycle with `reqValid` low leaves both `memValid` and `faultValid` low on the next clock.
- R12: While `rstN` is low, `memValid`, `faultValid`, `faultKind` and `faultCause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Linear address |
| reqSize | input | 2 | Size code: bytes = 1 << code |
| reqWrite | input | 1 | Write access |
| reqFetch | input | 1 | Code fetch |
| curPriv | input | 2 | Current privilege level, 3 = user |
| ctlAlignMask | input | 1 | Alignment-mask enable from the control register |
| flgAlignChk | input | 1 | Alignment-check enable from the flags register |
| pagePresent | input | 1 | Translated page present |
| pageUser | input | 1 | Page reachable from privilege 3 |
| pageWritable | input | 1 | Page allows writes |
| memValid | output | 1 | Forwarded request to memory |
| memAddr | output | ADDR_W | Forwarded address |
| memSize | output | 2 | Forwarded size code |
| memWrite | output | 1 | Forwarded write flag |
| memFetch | output | 1 | Forwarded fetch flag |
| faultValid | output | 1 | Fault report valid |
| faultKind | output | 2 | 0 none, 1 alignment, 2 page |
| faultCause | output | 3 | {user, write, present} for page faults |
| faultAddr | output | ADDR_W | Address of the faulting access |

## Verification
The bench builds the block with `ADDR_W` set to 20. With that width, the three low offset bits that set alignment for the largest size can be swept in full, while the upper bits are random, so address pass-through is still exercised. Every combination is driven: privilege level, both enable bits, all four size codes, all eight low offsets, all eight permission-bit patterns, and all four write/fetch pairings. That sweep reaches the case where page and alignment violations collide and the fetch-with-write corner. Idle cycles are interleaved with garbage on the request fields.

// File: rtl/accchk_pkg.sv
package accchk_pkg;

  localparam int PRIV_W      = 2;
  localparam int SIZE_CODE_W = 2;
  // widest access is 2**(2**SIZE_CODE_W - 1) bytes; offset bits that matter
  localparam int OFF_W       = (1 << SIZE_CODE_W) - 1;
  localparam int CAUSE_W     = 3;
  localparam logic [PRIV_W-1:0] USER_PRIV = 2'd3;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_ALIGN = 2'd1,
    FK_PAGE  = 2'd2
  } faultKind_e;

  // strobes from the decision logic into the registered datapath
  typedef struct packed {
    logic               fwdEn;
    logic               faultEn;
    faultKind_e         kind;
    logic [CAUSE_W-1:0] cause;
  } chkStrobe_t;

endpackage

// File: rtl/accchk_ctrl.sv
module accchk_ctrl
  import accchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   reqValid,
  input  logic [OFF_W-1:0]       addrLow,
  input  logic [SIZE_CODE_W-1:0] reqSize,
  input  logic                   reqWrite,
  input  logic                   reqFetch,
  input  logic [PRIV_W-1:0]      curPriv,
  input  logic                   ctlAlignMask,
  input  logic                   flgAlignChk,
  input  logic                   pagePresent,
  input  logic                   pageUser,
  input  logic                   pageWritable,
  output chkStrobe_t             strobe
);

  logic [OFF_W-1:0] sizeMask;
  logic isUser, isWrite, misaligned, alignOn, alignViol;
  logic domainViol, typeViol, pageViol;

  // bit i of the offset must be zero when the access is wider than 2**i bytes
  for (genvar i = 0; i < OFF_W; i++) begin : g_mask
    assign sizeMask[i] = (int'(reqSize) > i);
  end

  always_comb begin
    isUser     = (curPriv == USER_PRIV);
    isWrite    = reqWrite & ~reqFetch;
    misaligned = |(addrLow & sizeMask);
    alignOn    = isUser & ctlAlignMask & flgAlignChk;
    alignViol  = alignOn & misaligned;
    domainViol = isUser & ~pageUser;
    typeViol   = isWrite & ~pageWritable;
    pageViol   = ~pagePresent | domainViol | typeViol;

    strobe         = '0;
    strobe.kind    = FK_NONE;
    strobe.fwdEn   = reqValid & ~alignViol & ~pageViol;
    strobe.faultEn = reqValid & (alignViol | pageViol);
    if (reqValid && pageViol) begin
      strobe.kind  = FK_PAGE;
      strobe.cause = {isUser, isWrite, pagePresent};
    end else if (reqValid && alignViol) begin
      strobe.kind  = FK_ALIGN;
    end
  end

endmodule

// File: rtl/accchk_dp.sv
module accchk_dp
  import accchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  chkStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [SIZE_CODE_W-1:0] reqSize,
  input  logic                   reqWrite,
  input  logic                   reqFetch,
  output logic                   memValid,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [SIZE_CODE_W-1:0] memSize,
  output logic                   memWrite,
  output logic                   memFetch,
  output logic                   faultValid,
  output logic [1:0]             faultKind,
  output logic [CAUSE_W-1:0]     faultCause,
  output logic [ADDR_W-1:0]      faultAddr
);

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid   <= 1'b0;
      faultValid <= 1'b0;
      faultKind  <= FK_NONE;
      faultCause <= '0;
      addrQ      <= '0;
      memSize    <= '0;
      memWrite   <= 1'b0;
      memFetch   <= 1'b0;
    end else begin
      memValid   <= strobe.fwdEn;
      faultValid <= strobe.faultEn;
      faultKind  <= strobe.kind;
      faultCause <= strobe.cause;
      addrQ      <= reqAddr;
      memSize    <= reqSize;
      memWrite   <= reqWrite;
      memFetch   <= reqFetch;
    end
  end

  assign memAddr   = addrQ;
  assign faultAddr = addrQ;

endmodule

// File: rtl/accchk_top.sv
module accchk_top
  import accchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [1:0]        curPriv,
  input  logic              ctlAlignMask,
  input  logic              flgAlignChk,
  input  logic              pagePresent,
  input  logic              pageUser,
  input  logic              pageWritable,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic              memWrite,
  output logic              memFetch,
  output logic              faultValid,
  output logic [1:0]        faultKind,
  output logic [2:0]        faultCause,
  output logic [ADDR_W-1:0] faultAddr
);

  chkStrobe_t strobe;

  accchk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .reqValid     (reqValid),
    .addrLow      (reqAddr[OFF_W-1:0]),
    .reqSize      (reqSize),
    .reqWrite     (reqWrite),
    .reqFetch     (reqFetch),
    .curPriv      (curPriv),
    .ctlAlignMask (ctlAlignMask),
    .flgAlignChk  (flgAlignChk),
    .pagePresent  (pagePresent),
    .pageUser     (pageUser),
    .pageWritable (pageWritable),
    .strobe       (strobe)
  );

  accchk_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqFetch   (reqFetch),
    .memValid   (memValid),
    .memAddr    (memAddr),
    .memSize    (memSize),
    .memWrite   (memWrite),
    .memFetch   (memFetch),
    .faultValid (faultValid),
    .faultKind  (faultKind),
    .faultCause (faultCause),
    .faultAddr  (faultAddr)
  );

endmodule

// File: rtl/accchk_checker.sv
module accchk_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqFetch,
  input logic [1:0]        curPriv,
  input logic              ctlAlignMask,
  input logic              flgAlignChk,
  input logic              pagePresent,
  input logic              pageUser,
  input logic              pageWritable,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              faultValid,
  input logic [1:0]        faultKind,
  input logic [2:0]        faultCause
);

  // R10: forward and fault are exclusive
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memValid && faultValid));

  // R11: idle input produces nothing
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!memValid && !faultValid));

  // R3: no alignment fault below the user level
  assert_no_align_priv_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curPriv != 2'd3) |=> (faultKind != 2'd1));

  // R4: either enable clear means no alignment fault
  assert_no_align_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(ctlAlignMask && flgAlignChk)) |=> (faultKind != 2'd1));

  // R7: write to read-only page always faults
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqFetch && !pageWritable) |=> (faultValid && faultKind == 2'd2 && !memValid));

  // R8: absent page faults with the present cause bit clear
  assert_absent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !pagePresent) |=> (faultValid && faultKind == 2'd2 && faultCause[0] == 1'b0));

  // R6: user access to supervisor page faults
  assert_domain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && curPriv == 2'd3 && !pageUser) |=> (faultKind == 2'd2 && faultCause[2]));

  // R1: forwarded address tracks the request
  assert_fwd_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!memValid || memAddr == $past(reqAddr)));

endmodule

bind accchk_top accchk_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqAddr      (reqAddr),
  .reqWrite     (reqWrite),
  .reqFetch     (reqFetch),
  .curPriv      (curPriv),
  .ctlAlignMask (ctlAlignMask),
  .flgAlignChk  (flgAlignChk),
  .pagePresent  (pagePresent),
  .pageUser     (pageUser),
  .pageWritable (pageWritable),
  .memValid     (memValid),
  .memAddr      (memAddr),
  .faultValid   (faultValid),
  .faultKind    (faultKind),
  .faultCause   (faultCause)
);

// File: tb/accchk_top_bench.sv
module accchk_top_bench;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = '0;
  logic          reqWrite = 1'b0, reqFetch = 1'b0;
  logic [1:0]    curPriv = '0;
  logic          ctlAlignMask = 1'b0, flgAlignChk = 1'b0;
  logic          pagePresent = 1'b0, pageUser = 1'b0, pageWritable = 1'b0;
  logic          memValid, memWrite, memFetch, faultValid;
  logic [AW-1:0] memAddr, faultAddr;
  logic [1:0]    memSize, faultKind;
  logic [2:0]    faultCause;

  always #4 clk = ~clk;  // 125 MHz

  accchk_top #(.ADDR_W(AW)) u_accchk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .curPriv(curPriv), .ctlAlignMask(ctlAlignMask), .flgAlignChk(flgAlignChk),
    .pagePresent(pagePresent), .pageUser(pageUser), .pageWritable(pageWritable),
    .memValid(memValid), .memAddr(memAddr), .memSize(memSize),
    .memWrite(memWrite), .memFetch(memFetch), .faultValid(faultValid),
    .faultKind(faultKind), .faultCause(faultCause), .faultAddr(faultAddr)
  );

  typedef struct packed {
    logic          mv;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic          wr;
    logic          fe;
    logic          fv;
    logic [1:0]    kind;
    logic [2:0]    cause;
  } expect_t;

  expect_t  expQ[$];
  string    tagQ[$];
  int       compared = 0;
  int       mismatched = 0;
  bit       finished = 0;

  task automatic compare();
    expect_t e, a;
    string   tag;
    bit      bad;
    if (expQ.size() == 0) return;
    e   = expQ.pop_front();
    tag = tagQ.pop_front();
    a   = {memValid, memAddr, memSize, memWrite, memFetch, faultValid, faultKind, faultCause};
    bad = (a.mv != e.mv) || (a.fv != e.fv) || (a.kind != e.kind) || (a.cause != e.cause);
    if (e.mv && (a.addr != e.addr || a.size != e.size || a.wr != e.wr || a.fe != e.fe)) bad = 1;
    if (e.fv && faultAddr != e.addr) bad = 1;
    if (memValid && faultValid) begin bad = 1; tag = {tag, "/R10"}; end
    compared++;
    if (bad) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h faultAddr=%h", tag, a, e, faultAddr);
    end
  endtask

  task automatic drive(bit v, logic [AW-1:0] a, logic [1:0] sz, bit w, bit f,
                       logic [1:0] pl, bit am, bit ac, bit p, bit u, bit wb);
    expect_t e;
    string   tag;
    int      bytes = 1 << sz;
    bit      mis   = (int'(a[2:0]) % bytes) != 0;          // R5
    bit      usr   = (pl == 2'd3);
    bit      wrEff = w && !f;                              // R7: fetch is a read
    bit      domV  = usr && !u;                            // R6
    bit      typV  = wrEff && !wb;                         // R7
    bit      pv    = !p || domV || typV;                   // R8 for !p
    bit      av    = usr && am && ac && mis;               // R2, R3, R4
    reqValid = v; reqAddr = a; reqSize = sz; reqWrite = w; reqFetch = f;
    curPriv = pl; ctlAlignMask = am; flgAlignChk = ac;
    pagePresent = p; pageUser = u; pageWritable = wb;
    e.mv    = v && !pv && !av;                             // R1, R10
    e.fv    = v && (pv || av);
    e.kind  = !v ? 2'd0 : pv ? 2'd2 : av ? 2'd1 : 2'd0;    // R9: page wins
    e.cause = (v && pv) ? {usr, wrEff, p} : 3'd0;
    e.addr  = a; e.size = sz; e.wr = w; e.fe = f;
    if (!v) tag = "R11";
    else if (pv && av) tag = "R9";
    else if (!p) tag = "R8";
    else if (domV) tag = "R6";
    else if (typV) tag = "R7";
    else if (av) tag = "R2";
    else if (mis && usr) tag = "R4";
    else if (mis) tag = "R3";
    else tag = "R1";
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state of outputs
    compared++;
    if (memValid || faultValid || faultKind != 2'd0 || faultCause != 3'd0) begin
      mismatched++;
      $display("FAIL R12 actual=%b%b%h%h expected=0000", memValid, faultValid, faultKind, faultCause);
    end
    rstN = 1'b1;
    for (int pl = 0; pl < 4; pl++)
      for (int en = 0; en < 4; en++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 8; off++)
            for (int perm = 0; perm < 8; perm++)
              for (int mode = 0; mode < 4; mode++) begin
                logic [AW-1:0] addr;
                addr = AW'($urandom);
                addr[2:0] = off[2:0];
                @(negedge clk);
                compare();
                drive(1'b1, addr, sz[1:0], mode[0], mode[1], pl[1:0], en[1], en[0],
                      perm[2], perm[1], perm[0]);
                n++;
                if (n % 7 == 0) begin
                  // R11: idle cycle with junk on the fields
                  @(negedge clk);
                  compare();
                  drive(1'b0, AW'($urandom), 2'($urandom), 1'b1, 1'b0, 2'd3, 1'b1, 1'b1,
                        1'b0, 1'b0, 1'b0);
                end
              end
    @(negedge clk);
    compare();
    drive(1'b0, '0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    compare();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule